// File: doc/BRIEF.md
# Runtime-Configurable Fixed-Point Quantizer

This block takes a wide signed fixed-point sample and requantizes it to a narrower format. The format is not fixed when the hardware is built. It is held in a small configuration register that is loaded from live inputs when a load strobe is asserted. The loaded format sets the output word length, where the binary point sits in the result, whether overflow saturates or wraps, and how many register stages the sample passes through. Engineers can then sweep precision, range and timing on running hardware without rebuilding it.

The input is a 32-bit two's-complement value with 16 fractional bits. Each accepted sample is scaled to the selected number of fractional bits by truncation toward minus infinity. It is then fitted into the selected word length. The result leaves on a 32-bit bus, sign-extended from the top bit of the selected width, and is qualified by its own valid flag. That flag follows the input valid through the chosen delay.

Top module: `rt_quantizer`

## Requirements
- R1: With F output fractional bits, the numeric result is floor(x / 2^(16-F)), where x is `in_data` read as a signed 32-bit integer. Scaling always truncates toward minus infinity.
- R2: When `cfg_sat` = 1 was loaded, a scaled value above 2^(W-1)-1 becomes 2^(W-1)-1. A scaled value below -2^(W-1) becomes -2^(W-1). Here W is the loaded width.
- R3: When `cfg_sat` = 0 was loaded, only the low W bits of the scaled value are kept and read as a signed W-bit number.
- R4: Bits 31 down to W-1 of `out_data` all equal the sign of the W-bit result, so `out_data` is the result sign-extended to 32 bits.
- R5: The load clamps the requested settings. A width below 4 is stored as 4 and a width above 24 is stored as 24. Fractional bits above 16 are stored as 16. A latency above 3 is stored as 3.
- R6: With a loaded latency L in 0..3, a sample presented with `in_valid` high appears on `out_valid`/`out_data` L clock edges later. With L = 0 it appears in the same cycle, with no register in the path. Back-to-back samples come out back-to-back. Latency may only be changed while no sample is in flight.
- R7: The configuration inputs are captured only at a clock edge where `cfg_load` is high. A sample presented in the same cycle as the strobe uses the previous format. Samples from the next cycle on use the new one. Changing the configuration inputs without the strobe has no effect.
- R8: While `rst` is high, `out_valid` is low. After reset the format is width 16, 8 fractional bits, saturate, latency 1.
- R9: A sample is quantized when it enters. Reloading the width, fractional bits or overflow mode while the sample is still in the delay line does not change its output value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load strobe for the configuration inputs |
| cfg_width | input | 5 | Requested output word length in bits |
| cfg_frac | input | 5 | Requested number of output fractional bits |
| cfg_sat | input | 1 | 1 = saturate on overflow, 0 = wrap |
| cfg_lat | input | 2 | Requested latency in register stages |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | 32 | Signed input, 16 fractional bits |
| out_valid | output | 1 | Output sample qualifier |
| out_data | output | 32 | Requantized result, sign-extended |

## Verification
The bench builds the block with its default parameters: a 32-bit bus, 16 input fractional bits, widths from 4 to 24 and up to three delay stages. These values make every clamp edge reachable. Requests of width 2 and width 30 land on the 4-bit and 24-bit limits, and a fractional request of 31 lands on 16. Every delay from combinational pass-through to three stages is exercised with back-to-back bursts, and each result is timed against its expected cycle. The full delay line also lets a format reload overtake samples already in flight.

// File: rtl/qz_pkg.sv
package qz_pkg;
  localparam int CFG_WID_W = 5;
  localparam int CFG_FRC_W = 5;
  localparam int CFG_LAT_W = 2;

  typedef struct packed {
    logic [CFG_WID_W-1:0] width;
    logic [CFG_FRC_W-1:0] frac;
    logic                 sat;
    logic [CFG_LAT_W-1:0] lat;
  } qz_cfg_t;
endpackage

// File: rtl/qz_cfg_reg.sv
module qz_cfg_reg
  import qz_pkg::*;
#(
  parameter int MIN_OUT_W = 4,
  parameter int MAX_OUT_W = 24,
  parameter int IN_FRAC   = 16,
  parameter int MAX_LAT   = 3,
  parameter int RST_W     = 16,
  parameter int RST_FRAC  = 8,
  parameter bit RST_SAT   = 1'b1,
  parameter int RST_LAT   = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [CFG_WID_W-1:0] req_width,
  input  logic [CFG_FRC_W-1:0] req_frac,
  input  logic                 req_sat,
  input  logic [CFG_LAT_W-1:0] req_lat,
  output qz_cfg_t              cfg_q
);
  localparam logic [CFG_WID_W-1:0] W_LO  = CFG_WID_W'(MIN_OUT_W);
  localparam logic [CFG_WID_W-1:0] W_HI  = CFG_WID_W'(MAX_OUT_W);
  localparam logic [CFG_FRC_W-1:0] F_HI  = CFG_FRC_W'(IN_FRAC);
  localparam logic [CFG_LAT_W-1:0] L_HI  = CFG_LAT_W'(MAX_LAT);

  qz_cfg_t nxt;

  // Clamp requests into the supported range before they are stored.
  always_comb begin
    nxt.sat = req_sat;
    if (req_width < W_LO)      nxt.width = W_LO;
    else if (req_width > W_HI) nxt.width = W_HI;
    else                       nxt.width = req_width;
    nxt.frac = (req_frac > F_HI) ? F_HI : req_frac;
    nxt.lat  = (req_lat > L_HI) ? L_HI : req_lat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.width <= CFG_WID_W'(RST_W);
      cfg_q.frac  <= CFG_FRC_W'(RST_FRAC);
      cfg_q.sat   <= RST_SAT;
      cfg_q.lat   <= CFG_LAT_W'(RST_LAT);
    end else if (load) begin
      cfg_q <= nxt;
    end
  end
endmodule

// File: rtl/qz_core.sv
module qz_core
  import qz_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IN_FRAC = 16
) (
  input  qz_cfg_t           cfg,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int SH_W = $clog2(IN_FRAC + 1);
  localparam logic [DATA_W-1:0] UNIT = DATA_W'(1);

  logic [SH_W-1:0]          shamt;
  logic signed [DATA_W-1:0] scaled;
  logic signed [DATA_W-1:0] lim_hi;
  logic signed [DATA_W-1:0] lim_lo;
  logic [DATA_W-1:0]        mask;
  logic [DATA_W-1:0]        top_bit;
  logic [DATA_W-1:0]        low;
  logic [DATA_W-1:0]        wrapped;
  logic [DATA_W-1:0]        clamped;
  logic                     ovf_hi;
  logic                     ovf_lo;

  // Scale: arithmetic right shift truncates toward minus infinity.
  always_comb begin
    shamt  = SH_W'(IN_FRAC) - SH_W'(cfg.frac);
    scaled = $signed(din) >>> shamt;
  end

  // Per-width masks and limits.
  always_comb begin
    mask    = (UNIT << cfg.width) - UNIT;
    top_bit = UNIT << (cfg.width - CFG_WID_W'(1));
    lim_hi  = $signed(top_bit - UNIT);
    lim_lo  = $signed(~(top_bit - UNIT));
  end

  // Saturating path.
  always_comb begin
    ovf_hi = scaled > lim_hi;
    ovf_lo = scaled < lim_lo;
    if (ovf_hi)      clamped = lim_hi;
    else if (ovf_lo) clamped = lim_lo;
    else             clamped = scaled;
  end

  // Wrapping path: keep low bits, then sign-extend.
  always_comb begin
    low     = scaled & mask;
    wrapped = (|(low & top_bit)) ? (low | ~mask) : low;
  end

  assign dout = cfg.sat ? clamped : wrapped;
endmodule

// File: rtl/qz_delay.sv
module qz_delay #(
  parameter int DATA_W  = 32,
  parameter int MAX_LAT = 3,
  parameter int SEL_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  sel,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int NTAP = MAX_LAT + 1;

  logic              tap_v [NTAP];
  logic [DATA_W-1:0] tap_d [NTAP];

  assign tap_v[0] = in_valid;
  assign tap_d[0] = in_data;

  for (genvar g = 1; g < NTAP; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) tap_v[g] <= 1'b0;
      else     tap_v[g] <= tap_v[g-1];
    end
    // Data registers load only behind a valid sample and carry no reset.
    always_ff @(posedge clk) begin
      if (tap_v[g-1]) tap_d[g] <= tap_d[g-1];
    end
  end

  always_comb begin
    out_valid = tap_v[0];
    out_data  = tap_d[0];
    for (int i = 1; i < NTAP; i++) begin
      if (sel == SEL_W'(i)) begin
        out_valid = tap_v[i];
        out_data  = tap_d[i];
      end
    end
  end
endmodule

// File: rtl/rt_quantizer.sv
module rt_quantizer
  import qz_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IN_FRAC   = 16,
  parameter int MIN_OUT_W = 4,
  parameter int MAX_OUT_W = 24,
  parameter int MAX_LAT   = 3,
  parameter int RST_W     = 16,
  parameter int RST_FRAC  = 8,
  parameter bit RST_SAT   = 1'b1,
  parameter int RST_LAT   = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_load,
  input  logic [CFG_WID_W-1:0] cfg_width,
  input  logic [CFG_FRC_W-1:0] cfg_frac,
  input  logic                 cfg_sat,
  input  logic [CFG_LAT_W-1:0] cfg_lat,
  input  logic                 in_valid,
  input  logic [DATA_W-1:0]    in_data,
  output logic                 out_valid,
  output logic [DATA_W-1:0]    out_data
);
  qz_cfg_t           act_cfg;
  logic [DATA_W-1:0] q_data;

  qz_cfg_reg #(
    .MIN_OUT_W(MIN_OUT_W), .MAX_OUT_W(MAX_OUT_W), .IN_FRAC(IN_FRAC),
    .MAX_LAT(MAX_LAT), .RST_W(RST_W), .RST_FRAC(RST_FRAC),
    .RST_SAT(RST_SAT), .RST_LAT(RST_LAT)
  ) u_cfg (
    .clk(clk), .rst(rst), .load(cfg_load),
    .req_width(cfg_width), .req_frac(cfg_frac),
    .req_sat(cfg_sat), .req_lat(cfg_lat),
    .cfg_q(act_cfg)
  );

  qz_core #(.DATA_W(DATA_W), .IN_FRAC(IN_FRAC)) u_core (
    .cfg(act_cfg), .din(in_data), .dout(q_data)
  );

  qz_delay #(.DATA_W(DATA_W), .MAX_LAT(MAX_LAT), .SEL_W(CFG_LAT_W)) u_dly (
    .clk(clk), .rst(rst), .sel(act_cfg.lat),
    .in_valid(in_valid), .in_data(q_data),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/qz_checker.sv
module qz_checker
  import qz_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IN_FRAC   = 16,
  parameter int MIN_OUT_W = 4,
  parameter int MAX_OUT_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_load,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input qz_cfg_t           cfg
);
  logic signed [DATA_W-1:0] ext_top;
  assign ext_top = $signed(out_data) >>> (cfg.width - CFG_WID_W'(1));

  // R4: everything above the result's sign position copies the sign.
  a_r4_sign_extended: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cfg.lat == '0) |-> (ext_top == '0 || ext_top == '1));

  // R2: saturation never turns a non-negative input negative.
  a_r2_no_sign_flip: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cfg.lat == '0 && cfg.sat && !in_data[DATA_W-1])
      |-> !out_data[DATA_W-1]);

  // R5: stored format stays inside the supported range.
  a_r5_cfg_in_range: assert property (@(posedge clk) disable iff (rst)
    (int'(cfg.width) >= MIN_OUT_W && int'(cfg.width) <= MAX_OUT_W
     && int'(cfg.frac) <= IN_FRAC));

  // R6: zero latency passes the qualifier straight through.
  a_r6_pass_through: assert property (@(posedge clk) disable iff (rst)
    (cfg.lat == '0) |-> (out_valid == in_valid));

  // R6: one stage delays the qualifier by exactly one edge.
  a_r6_one_stage: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cfg.lat == CFG_LAT_W'(1) && $past(cfg.lat) == CFG_LAT_W'(1))
      |-> (out_valid == $past(in_valid)));

  // R7: without the strobe the stored format does not move.
  a_r7_cfg_holds: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> $stable(cfg));
endmodule

bind rt_quantizer qz_checker #(
  .DATA_W(DATA_W), .IN_FRAC(IN_FRAC),
  .MIN_OUT_W(MIN_OUT_W), .MAX_OUT_W(MAX_OUT_W)
) u_qz_checker (
  .clk(clk), .rst(rst), .cfg_load(cfg_load),
  .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data), .cfg(act_cfg)
);

// File: tb/rt_quantizer_bench.sv
`timescale 1ns/100ps
module rt_quantizer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_load = 1'b0;
  logic [4:0]  cfg_width = 5'd16;
  logic [4:0]  cfg_frac = 5'd8;
  logic        cfg_sat = 1'b1;
  logic [1:0]  cfg_lat = 2'd1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [31:0] out_data;

  always #2.5 clk = ~clk;

  rt_quantizer u_rt_quantizer (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_width(cfg_width),
    .cfg_frac(cfg_frac), .cfg_sat(cfg_sat), .cfg_lat(cfg_lat),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  // Bench copy of the loaded format (R5 clamps applied here).
  int sh_w = 16, sh_f = 8, sh_lat = 1;
  bit sh_sat = 1;

  logic [31:0] exp_q[$];
  int          due_q[$];
  string       tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] model(logic [31:0] x, int w, int f, bit sat);
    longint v, hi, lo, m;
    v  = longint'($signed(x));
    v  = v >>> (16 - f);
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -hi - 1;
    if (sat) begin
      m = (v > hi) ? hi : ((v < lo) ? lo : v);
    end else begin
      m = v & ((longint'(1) <<< w) - 1);
      if (m > hi) m = m - (longint'(1) <<< w);
    end
    return m[31:0];
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Driver: present one sample and record its expected result and cycle.
  task automatic send(logic [31:0] x, string tag);
    in_valid = 1'b1;
    in_data  = x;
    exp_q.push_back(model(x, sh_w, sh_f, sh_sat));
    due_q.push_back(cyc + sh_lat);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic set_req(int w, int f, bit s, int l);
    cfg_width = 5'(w); cfg_frac = 5'(f); cfg_sat = s; cfg_lat = 2'(l);
  endtask

  task automatic commit_shadow(int w, int f, bit s, int l);
    sh_w   = (w < 4) ? 4 : ((w > 24) ? 24 : w);
    sh_f   = (f > 16) ? 16 : f;
    sh_sat = s;
    sh_lat = (l > 3) ? 3 : l;
  endtask

  task automatic load(int w, int f, bit s, int l);
    set_req(w, f, s, l);
    cfg_load = 1'b1;
    @(posedge clk); #1;
    cfg_load = 1'b0;
    commit_shadow(w, f, s, l);
  endtask

  // Monitor: pop and compare each result, including its arrival cycle.
  always @(negedge clk) begin
    if (rst) begin
      check(!out_valid, "R8 valid low in reset", 32'(out_valid), 32'h0);
    end else if (out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected output", out_data, 32'h0);
      end else begin
        logic [31:0] e;
        int d;
        string t;
        e = exp_q.pop_front();
        d = due_q.pop_front();
        t = tag_q.pop_front();
        check(out_data === e, t, out_data, e);
        if (d != cyc) check(1'b0, {t, " R6 timing"}, 32'(cyc), 32'(d));
      end
    end
  end

  initial begin
    #(5ns * 200000);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R8 defaults: width 16, 8 frac bits, saturate, latency 1.
    send(32'h0001_8000, "R8 default format");
    send(32'h7FFF_FFFF, "R8 default saturate");
    drain();

    // R1 truncation toward minus infinity.
    send(32'hFFFF_FFFF, "R1 tiny negative floors");
    send(32'h0000_00FF, "R1 tiny positive floors");
    send(32'hFFFE_C0A5, "R1 negative fraction");
    drain();

    // R2 saturation, width 8, 4 frac bits, latency 0.
    load(8, 4, 1, 0);
    send(32'h0064_0000, "R2 clamp high");
    send(32'hFF9C_0000, "R2 clamp low");
    send(32'h0007_8000, "R2 in range");
    drain();

    // R3 wrap, same width.
    load(8, 4, 0, 0);
    send(32'h0064_0000, "R3 wrap positive");
    send(32'h0009_0000, "R3 wrap to negative");
    send(32'hFF9C_0000, "R3 wrap negative");
    drain();

    // R5 clamping of requests.
    load(2, 31, 1, 0);
    send(32'h0003_0000, "R5 width clamps to 4");
    send(32'h0000_0003, "R5 frac clamps to 16");
    drain();
    load(30, 16, 1, 2);
    send(32'h7FFF_FFFF, "R5 width clamps to 24");
    send(32'h8000_0000, "R5 width clamps to 24 low");
    drain();

    // R6 every latency, back-to-back bursts; R4 checked on full bus.
    for (int l = 0; l < 4; l++) begin
      load(12, 6, 0, l);
      drain();
      for (int k = 0; k < 5; k++)
        send(32'(k * 32'h0013_57A1) ^ 32'hA5A5_0000, "R6 R4 burst");
      drain();
    end

    // R7 sample on the strobe cycle keeps the old format.
    load(8, 0, 1, 0);
    set_req(12, 4, 1, 0);
    cfg_load = 1'b1;
    in_valid = 1'b1;
    in_data  = 32'h0032_0000;
    exp_q.push_back(model(32'h0032_0000, sh_w, sh_f, sh_sat));
    due_q.push_back(cyc + sh_lat);
    tag_q.push_back("R7 strobe cycle uses old format");
    @(posedge clk); #1;
    cfg_load = 1'b0;
    in_valid = 1'b0;
    commit_shadow(12, 4, 1, 0);
    send(32'h0032_0000, "R7 next sample uses new format");
    set_req(4, 0, 0, 3);
    @(posedge clk); #1;
    send(32'h0032_0000, "R7 inputs ignored without strobe");
    drain();

    // R9 reload format while samples sit in a 3-stage line.
    load(16, 8, 1, 3);
    drain();
    send(32'h0123_4567, "R9 in flight keeps format");
    send(32'hF876_5432, "R9 in flight keeps format 2");
    load(5, 2, 0, 3);
    send(32'h0123_4567, "R9 after reload");
    drain();

    // R8 reset restores default format.
    check(exp_q.size() == 0, "R6 queue drained", 32'(exp_q.size()), 32'h0);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    commit_shadow(16, 8, 1, 1);
    send(32'h0001_8000, "R8 format after reset");
    drain();

    check(exp_q.size() == 0, "R6 all outputs seen", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule